// File: doc/BRIEF.md
# Per-Sample-Period Edge Timestamp Channels

This block tells a host, for every sample period of a data acquisition system, whether an external rising edge arrived in that period and on which system-clock tick. A free-running period counter divides time into frames whose length in ticks is programmed as the ratio of system clock frequency to sample rate. Each of several independent timing channels watches its own asynchronous input. At the end of every frame it reports either the tick offset of the first rising edge seen in the frame or, if no edge came, the frame length itself as a "nothing happened" marker.

At each frame boundary the block takes a snapshot of the analog sample words that are presented to it and of the channel results. It then sends them out as one frame of 16-bit words on a valid/ready stream. Enabled analog words come first. Each enabled timing channel follows as two words. A host adds up frame lengths and offsets to place events on an absolute time line.

Top module: `edge_stamp_top`

## Requirements
- R1: Only a low-to-high transition of `ext_in[c]` is detected. The input passes through two synchronizer flops. A rise first sampled by the clock edge that ends the cycle in which the period counter reads k is credited to counter value k+2, which may fall in the next frame. A high-to-low transition has no effect.
- R2: The period counter starts at 0 after reset. It counts 0, 1, ..., `period_max`-1 and then wraps to 0. `period_max` is 22 bits wide and covers 128 to 2,457,600 ticks. The cycle in which the counter reads `period_max`-1 is the frame boundary.
- R3: A channel that saw no rising edge during a frame reports the 32-bit value `period_max`.
- R4: A channel that saw rising edges during a frame reports the counter value credited to the first of them. Later edges in the same frame are ignored. An edge credited to the boundary cycle reports `period_max`-1. An edge credited to the cycle after the boundary reports 0 in the following frame.
- R5: Channels are independent. Edges on one channel never change another channel's result.
- R6: A frame is emitted in this order. First come the analog words whose `ana_en` bit is set, in ascending index order, where word i is `ana_words[16*i+15:16*i]`. Then, for channel 0 and then channel 1 when enabled, come bits 15:0 of the result followed by bits 31:16. Analog words and results are snapshots taken at the boundary.
- R7: A cleared `ch_en[c]` or `ana_en[i]` bit removes that channel's two words or that analog word from the frame. Enables are sampled at the boundary.
- R8: A word is transferred on a cycle with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R9: A new frame is loaded at a boundary only if the previous frame's last word has been transferred by the end of that boundary cycle, which includes a transfer in the boundary cycle itself. Otherwise the results of the frame just ended are discarded and the pending words stay unchanged.
- R10: While `rst` is high, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the timestamp tick |
| rst | input | 1 | Synchronous active-high reset |
| period_max | input | 22 | Frame length in ticks (clock/sample-rate ratio) |
| ext_in | input | 2 | Asynchronous external event inputs, one per channel |
| ana_words | input | 128 | Eight 16-bit analog sample words, word i at bits 16i+15:16i |
| ana_en | input | 8 | Per-analog-word enable |
| ch_en | input | 2 | Per-timing-channel enable |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Stream word valid |
| out_data | output | 16 | Stream word |

## Verification
Two events can fall in the same cycle: the handshake of the pending frame's last word, and the frame boundary that wants to load the next snapshot. The bench holds `out_ready` low and releases it exactly as many cycles before the boundary as the frame has words, so that the last transfer lands on the boundary. It then repeats the test with the release one cycle later. In the first case the next frame must follow without a gap. In the second case the frame just ended must be missing from the stream. The same edge-on-edge concern is covered for the channels: inputs are timed so that an edge is credited to the last tick of a frame and to tick 0 of the next.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

    localparam int WORD_W  = 16;
    localparam int STAMP_W = 2 * WORD_W;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [STAMP_W-1:0] stamp_t;

    // A stamp as it travels on the stream: low half first.
    typedef struct packed {
        word_t hi;
        word_t lo;
    } stamp_split_t;

    function automatic stamp_split_t split_stamp(input stamp_t v);
        stamp_split_t s;
        s.hi = v[STAMP_W-1:WORD_W];
        s.lo = v[WORD_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/period_gen.sv
module period_gen #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_max,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    // Wrap on >= so a shrinking period_max cannot strand the counter.
    assign wrap = (cnt >= period_max - 1'b1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/edge_sync.sv
module edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/stamp_chan.sv
module stamp_chan import edge_stamp_pkg::*; #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    input  logic [CNT_W-1:0] period_max,
    output stamp_t           result
);
    logic             seen_q;
    logic [CNT_W-1:0] first_q;

    // Value of the frame that closes in a wrap cycle; an edge in the
    // wrap cycle itself still belongs to the closing frame.
    always_comb begin
        if (seen_q)    result = stamp_t'(first_q);
        else if (rise) result = stamp_t'(cnt);
        else           result = stamp_t'(period_max);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            first_q <= '0;
        end else if (wrap) begin
            seen_q  <= 1'b0;
        end else if (rise && !seen_q) begin
            seen_q  <= 1'b1;
            first_q <= cnt;
        end
    end
endmodule

// File: rtl/frame_ser.sv
module frame_ser import edge_stamp_pkg::*; #(
    parameter int NANA = 8,
    parameter int NCH  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  word_t [NANA-1:0]    ana_arr,
    input  logic  [NANA-1:0]    ana_en,
    input  stamp_t [NCH-1:0]    ch_res,
    input  logic  [NCH-1:0]     ch_en,
    input  logic                out_ready,
    output logic                out_valid,
    output word_t               out_data
);
    localparam int NW = NANA + 2 * NCH;
    localparam int IW = (NW > 1) ? $clog2(NW) : 1;

    word_t [NW-1:0] words_q, words_new;
    logic  [NW-1:0] mask_q, mask_new, mask_drain;
    logic  [IW-1:0] sel;
    logic           xfer;

    // Lowest pending slot goes first: analog words, then channel halves.
    always_comb begin
        sel = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (mask_q[i]) sel = IW'(i);
        end
    end

    assign out_valid  = |mask_q;
    assign out_data   = words_q[sel];
    assign xfer       = out_valid & out_ready;
    assign mask_drain = mask_q & ~(xfer ? (NW'(1) << sel) : '0);

    for (genvar i = 0; i < NANA; i++) begin : g_ana
        assign words_new[i] = ana_arr[i];
        assign mask_new[i]  = ana_en[i];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        stamp_split_t parts;
        assign parts                     = split_stamp(ch_res[c]);
        assign words_new[NANA + 2*c]     = parts.lo;
        assign words_new[NANA + 2*c + 1] = parts.hi;
        assign mask_new[NANA + 2*c]      = ch_en[c];
        assign mask_new[NANA + 2*c + 1]  = ch_en[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            words_q <= '0;
        end else if (load && (mask_drain == '0)) begin
            mask_q  <= mask_new;
            words_q <= words_new;
        end else begin
            mask_q  <= mask_drain;
        end
    end
endmodule

// File: rtl/edge_stamp_top.sv
module edge_stamp_top import edge_stamp_pkg::*; #(
    parameter int NANA  = 8,
    parameter int NCH   = 2,
    parameter int CNT_W = 22
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CNT_W-1:0]       period_max,
    input  logic [NCH-1:0]         ext_in,
    input  logic [NANA*WORD_W-1:0] ana_words,
    input  logic [NANA-1:0]        ana_en,
    input  logic [NCH-1:0]         ch_en,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [WORD_W-1:0]      out_data
);
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [NCH-1:0]   rise;
    stamp_t [NCH-1:0] ch_res;
    word_t [NANA-1:0] ana_arr;

    period_gen #(.CNT_W(CNT_W)) u_period (
        .clk(clk), .rst(rst), .period_max(period_max),
        .cnt(cnt), .wrap(wrap)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        edge_sync u_sync (
            .clk(clk), .rst(rst), .din(ext_in[c]), .rise(rise[c])
        );
        stamp_chan #(.CNT_W(CNT_W)) u_stamp (
            .clk(clk), .rst(rst), .rise(rise[c]), .cnt(cnt),
            .wrap(wrap), .period_max(period_max), .result(ch_res[c])
        );
    end

    for (genvar i = 0; i < NANA; i++) begin : g_unpack
        assign ana_arr[i] = ana_words[i*WORD_W +: WORD_W];
    end

    frame_ser #(.NANA(NANA), .NCH(NCH)) u_ser (
        .clk(clk), .rst(rst), .load(wrap),
        .ana_arr(ana_arr), .ana_en(ana_en),
        .ch_res(ch_res), .ch_en(ch_en),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: rtl/edge_stamp_chk.sv
module edge_stamp_chk #(
    parameter int NCH   = 2,
    parameter int CNT_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  period_max,
    input logic [CNT_W-1:0]  cnt,
    input logic              wrap,
    input logic [NCH*32-1:0] ch_res,
    input logic              out_valid,
    input logic              out_ready,
    input logic [15:0]       out_data
);
    logic [31:0] max_ext;
    assign max_ext = {{(32-CNT_W){1'b0}}, period_max};

    // R2: counter stays inside the frame
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt < period_max);

    // R2: counter steps by one between boundaries
    a_r2_cnt_step: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R2: counter restarts after a boundary
    a_r2_cnt_restart: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt == '0);

    // R3/R4: a closing result never exceeds the frame length
    for (genvar c = 0; c < NCH; c++) begin : g_bound
        a_r3_bounded: assert property (@(posedge clk) disable iff (rst)
            wrap |-> ch_res[c*32 +: 32] <= max_ext);
    end

    // R8: stalled word holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8: valid only drops after an accepted word
    a_r8_drop_after_xfer: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_ready));
endmodule

bind edge_stamp_top edge_stamp_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .period_max(period_max), .cnt(cnt), .wrap(wrap),
    .ch_res(ch_res), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
);

// File: tb/test_edge_stamp_top.sv
module test_edge_stamp_top;
    localparam int CLK_PERIOD = 10;
    localparam int NANA  = 8;
    localparam int NCH   = 2;
    localparam int CNT_W = 22;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [CNT_W-1:0]   period_max = 22'd128;
    logic [NCH-1:0]     ext_in = '0;
    logic [NANA*16-1:0] ana_words = '0;
    logic [NANA-1:0]    ana_en = '0;
    logic [NCH-1:0]     ch_en = '0;
    logic               out_ready = 1'b1;
    logic               out_valid;
    logic [15:0]        out_data;

    edge_stamp_top #(.NANA(NANA), .NCH(NCH), .CNT_W(CNT_W)) i_edge_stamp_top (
        .clk(clk), .rst(rst), .period_max(period_max), .ext_in(ext_in),
        .ana_words(ana_words), .ana_en(ana_en), .ch_en(ch_en),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int kcnt = 0;
    bit mon_on = 0;
    int exp_q[$];
    int rises[2][$];
    int first_off[int];

    always @(posedge clk) begin
        if (rst) kcnt <= 0;
        else     kcnt <= kcnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int p, input int i, input int m);
        return 16'((i + 1) * 16'h0101 + p * 7 + m);
    endfunction

    // Scoreboard monitor: samples handshakes between edges.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected word", int'(out_data), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    // R6 order, R3/R4 values, R5 per channel, R7 enables
                    check(out_data == e[15:0], "R6/R4 frame word", int'(out_data), e);
                end
            end
        end
    end

    // Driver: pushes the expected frame for period p.
    task automatic push_frame(input int p, input int m, input logic [7:0] aen, input logic [1:0] cen);
        for (int i = 0; i < NANA; i++)
            if (aen[i]) exp_q.push_back(int'(pat(p, i, m)));
        for (int c = 0; c < NCH; c++) begin
            if (cen[c]) begin
                int v;
                // R3: no edge gives the frame length; R4: first edge offset
                v = first_off.exists(p*2 + c) ? first_off[p*2 + c] : m;
                exp_q.push_back(v & 16'hFFFF);
                exp_q.push_back((v >> 16) & 16'hFFFF);
            end
        end
    endtask

    task automatic run_phase(input int m, input logic [7:0] aen, input logic [1:0] cen,
                             input int nper, input int skip, input int rmode, input int rel);
        rst = 1'b1;
        mon_on = 0;
        period_max = CNT_W'(m);
        ana_en = aen;
        ch_en = cen;
        ext_in = '0;
        out_ready = (rmode == 0);
        first_off.delete();
        exp_q.delete();
        for (int i = 0; i < NANA; i++) ana_words[i*16 +: 16] = pat(0, i, m);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10 valid low in reset", int'(out_valid), 0);
        rst = 1'b0;
        mon_on = 1;
        for (int a = 0; a < nper * m; a++) begin
            int t, p;
            if (a > 0) @(negedge clk);
            t = a % m;
            p = a / m;
            if (t == 0)
                for (int i = 0; i < NANA; i++) ana_words[i*16 +: 16] = pat(p, i, m);
            if (rmode == 1) out_ready = (a % 3 != 0);
            else if (rmode == 2) out_ready = (a >= rel);
            for (int c = 0; c < NCH; c++) begin
                logic lvl;
                lvl = 1'b0;
                foreach (rises[c][k]) begin
                    if (a >= rises[c][k] && a <= rises[c][k] + 2) lvl = 1'b1;
                    // R1: credited two ticks after the sampling edge
                    if (a == rises[c][k]) begin
                        int cr;
                        cr = a + 2;
                        if (!first_off.exists((cr / m) * 2 + c))
                            first_off[(cr / m) * 2 + c] = cr % m;
                    end
                end
                ext_in[c] = lvl;
            end
            // R9: a skipped period contributes nothing
            if (t == m - 1 && p != skip) push_frame(p, m, aen, cen);
        end
        out_ready = 1'b1;
        repeat (24) @(negedge clk);
        mon_on = 0;
        check(exp_q.size() == 0, "R7/R9 all expected words seen", exp_q.size(), 0);
        rises[0].delete();
        rises[1].delete();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // Phase A: R3, R4 (second edge ignored, tick 0, last tick), R5, R1 falling ignored
        rises[0] = '{10, 40, 254, 509, 572};
        rises[1] = '{126, 300, 400, 410, 740};
        run_phase(128, 8'hFF, 2'b11, 6, -1, 0, 0);
        // Phase B: R7 partial analog enables, channel 1 disabled, R8 stalls
        rises[0] = '{5, 250, 260};
        rises[1] = '{30, 450};
        run_phase(200, 8'hA5, 2'b01, 4, -1, 1, 0);
        // Phase C: R7 analog all off, only channel 1, R4 tick-0 edge
        rises[0] = '{50};
        rises[1] = '{100, 398};
        run_phase(200, 8'h00, 2'b10, 3, -1, 1, 0);
        // Phase D: R9 long stall, period 1 discarded
        rises[0] = '{20, 150, 300};
        rises[1] = '{60};
        run_phase(128, 8'hFF, 2'b11, 4, 1, 2, 2*128 + 50);
        // Phase E: R9 last word exactly on the boundary, nothing lost
        rises[0] = '{20, 140};
        rises[1] = '{70, 200};
        run_phase(128, 8'hFF, 2'b11, 3, -1, 2, 128 + 116);
        // Phase F: R9 last word one tick late, period 1 discarded
        rises[0] = '{20, 140};
        rises[1] = '{70, 200};
        run_phase(128, 8'hFF, 2'b11, 3, 1, 2, 128 + 117);
        // Phase G: R2 long frame, high result words nonzero (R3, R4)
        rises[0] = '{68998};
        run_phase(70000, 8'h01, 2'b11, 1, -1, 0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule